// File: doc/BRIEF.md
# Page Translation Buffer

This block caches page translations. It maps a virtual page number to a physical page number for a fixed page size of 4 KiB. Every slot can hold any page, and a lookup compares the incoming page number against all slots at the same time, with one comparator per slot. The low twelve address bits pass through without change. The upper bits are replaced by the physical page number of the slot that matches.

Each slot keeps two status bits that the hardware maintains. A use bit is set by any hit. A modified bit is set by a write hit. Software clears all use bits together from time to time, so a slot whose use bit is 0 counts as not recently used. On a miss, a walker outside this block fetches the translation, installs it through the fill port, and then retries the access.

When the fill port installs a page, it picks the slot to overwrite in this order. First comes a slot that already holds the same page. Next comes the lowest free slot. Next comes the lowest slot whose use bit is clear. If none of these exists, slot 0 is used. This approximates least-recently-used replacement. A flush input empties the whole buffer in one cycle.

Top module: `tlb_translator`

## Requirements
- R1: After reset, every slot is empty, so every valid lookup reports a miss.
- R2: On a hit, `lk_paddr` is the slot's physical page number joined to `lk_vaddr[11:0]`, and it appears combinationally in the same cycle as the lookup.
- R3: `lk_miss` is 1 exactly when `lk_valid` is 1 and no slot matches. `lk_hit` and `lk_miss` are never both 1. With `lk_valid` at 0, both are 0 and no status bit changes.
- R4: `lk_ref` shows the hitting slot's use bit as it was before the access. Any hit sets that bit at the next clock edge.
- R5: A hit with `lk_write`=1 sets the slot's modified bit (shown on `lk_dirty`) at the next edge. A read hit leaves the modified bit unchanged.
- R6: `ref_clr` clears every use bit at the next edge and leaves the modified bits unchanged. If a hit happens in the same cycle, the hitting slot's use bit ends at 1.
- R7: A fill whose page number already sits in a valid slot overwrites that slot, so no page is ever held twice.
- R8: Otherwise, a fill uses the lowest-numbered empty slot.
- R9: If every slot is valid, a fill uses the lowest slot whose use bit is 0. If all use bits are 1, it uses slot 0.
- R10: A filled slot becomes valid with the new page numbers, its use bit at 0 and its modified bit at 0.
- R11: `flush` empties every slot at the next edge. It takes priority over a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| ref_clr | input | 1 | Clear every use bit |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; fill and retry |
| lk_paddr | output | 32 | Translated physical address |
| lk_ref | output | 1 | Use bit of the hitting slot before this access |
| lk_dirty | output | 1 | Modified bit of the hitting slot before this access |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |

## Verification
The hit, miss, address and status outputs are combinational, so they are due in the same cycle as the lookup. The bench drives each request on the falling edge and samples one nanosecond later, before the next rising edge. A fill, a flush, a use-bit clear or a status update takes effect at the single rising edge that follows it. Each check therefore looks at that effect through a fresh lookup made in the next cycle. Replacement order is observed only through which pages still hit after a further fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int unsigned PAGE_OFS_W = 12;
    parameter int unsigned VPN_W      = 20;
    parameter int unsigned PPN_W      = 20;
    parameter int unsigned VADDR_W    = VPN_W + PAGE_OFS_W;
    parameter int unsigned PADDR_W    = PPN_W + PAGE_OFS_W;

    typedef logic [VPN_W-1:0]      vpn_t;
    typedef logic [PPN_W-1:0]      ppn_t;
    typedef logic [PAGE_OFS_W-1:0] pofs_t;
    typedef logic [PADDR_W-1:0]    paddr_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
        logic used;
        logic modified;
    } slot_t;

    typedef struct packed {
        logic en;
        vpn_t vpn;
        ppn_t ppn;
    } fill_req_t;

    function automatic paddr_t join_paddr(ppn_t ppn, pofs_t ofs);
        return {ppn, ofs};
    endfunction

    function automatic vpn_t vpn_of(logic [VADDR_W-1:0] va);
        return va[VADDR_W-1:PAGE_OFS_W];
    endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      ref_clr,
    input  logic      lk_valid,
    input  logic      lk_write,
    input  vpn_t      lk_vpn,
    input  logic      fill_sel,
    input  fill_req_t fill,
    output logic      valid_o,
    output logic      used_o,
    output logic      modified_o,
    output ppn_t      ppn_o,
    output logic      lk_match,
    output logic      fill_match
);

    slot_t s_q;
    logic  touch;

    assign lk_match   = s_q.valid && (s_q.vpn == lk_vpn);
    assign fill_match = s_q.valid && (s_q.vpn == fill.vpn);
    assign touch      = lk_valid && lk_match;

    assign valid_o    = s_q.valid;
    assign used_o     = s_q.used;
    assign modified_o = s_q.modified;
    assign ppn_o      = s_q.ppn;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (flush) begin
            s_q.valid <= 1'b0;
        end else if (fill_sel) begin
            s_q <= '{valid: 1'b1, vpn: fill.vpn, ppn: fill.ppn,
                     used: 1'b0, modified: 1'b0};
        end else begin
            if (ref_clr)
                s_q.used <= 1'b0;
            if (touch) begin
                s_q.used <= 1'b1;
                if (lk_write)
                    s_q.modified <= 1'b1;
            end
        end
    end

    // R4: a hit marks the slot as recently used
    a_r4_use_set: assert property (@(posedge clk) disable iff (rst)
        (touch && !flush && !fill_sel) |=> s_q.used);

    // R5: a write hit marks the slot modified
    a_r5_mod_set: assert property (@(posedge clk) disable iff (rst)
        (touch && lk_write && !flush && !fill_sel) |=> s_q.modified);

    // R5: without a write hit or a fill the modified bit holds
    a_r5_mod_hold: assert property (@(posedge clk) disable iff (rst)
        (!fill_sel && !(touch && lk_write)) |=> $stable(s_q.modified));

    // R10: a fill installs a fresh, unused, clean slot
    a_r10_fill_fresh: assert property (@(posedge clk) disable iff (rst)
        (fill_sel && !flush) |=> (s_q.valid && !s_q.used && !s_q.modified));

    // R11: flush empties the slot
    a_r11_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> !s_q.valid);

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] used_vec,
    input  logic [ENTRIES-1:0] fmatch_vec,
    output logic [IDX_W-1:0]   victim
);

    logic             any_match, any_free, any_cold;
    logic [IDX_W-1:0] match_idx, free_idx, cold_idx;

    always_comb begin
        any_match = 1'b0;
        any_free  = 1'b0;
        any_cold  = 1'b0;
        match_idx = '0;
        free_idx  = '0;
        cold_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fmatch_vec[i]) begin
                any_match = 1'b1;
                match_idx = IDX_W'(i);
            end
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (valid_vec[i] && !used_vec[i]) begin
                any_cold = 1'b1;
                cold_idx = IDX_W'(i);
            end
        end
        if (any_match)
            victim = match_idx;
        else if (any_free)
            victim = free_idx;
        else if (any_cold)
            victim = cold_idx;
        else
            victim = '0;
    end

    // R8: an empty slot is taken before any valid one
    a_r8_free_first: assert property (@(posedge clk) disable iff (rst)
        (!(|fmatch_vec) && !(&valid_vec)) |-> !valid_vec[victim]);

    // R9: with all slots valid, a cold slot is preferred when one exists
    a_r9_cold_pick: assert property (@(posedge clk) disable iff (rst)
        (!(|fmatch_vec) && (&valid_vec) && !(&used_vec)) |-> !used_vec[victim]);

    // R7: a slot holding the same page is reused
    a_r7_reuse: assert property (@(posedge clk) disable iff (rst)
        (|fmatch_vec) |-> fmatch_vec[victim]);

endmodule

// File: rtl/tlb_hit_mux.sv
module tlb_hit_mux
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic [ENTRIES-1:0] used_vec,
    input  logic [ENTRIES-1:0] mod_vec,
    input  ppn_t               ppn_arr [ENTRIES],
    output logic               any_hit,
    output ppn_t               hit_ppn,
    output logic               hit_used,
    output logic               hit_mod
);

    ppn_t ppn_acc [ENTRIES+1];

    assign ppn_acc[0] = '0;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_or
        assign ppn_acc[g+1] = ppn_acc[g] | (ppn_arr[g] & {PPN_W{match_vec[g]}});
    end

    assign any_hit  = |match_vec;
    assign hit_ppn  = ppn_acc[ENTRIES];
    assign hit_used = |(used_vec & match_vec);
    assign hit_mod  = |(mod_vec & match_vec);

    // R7: the fill policy never leaves a page in two slots
    a_r7_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: rtl/tlb_translator.sv
module tlb_translator
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush,
    input  logic                                ref_clr,
    input  logic                                lk_valid,
    input  logic                                lk_write,
    input  logic [tlb_pkg::VADDR_W-1:0]         lk_vaddr,
    output logic                                lk_hit,
    output logic                                lk_miss,
    output logic [tlb_pkg::PADDR_W-1:0]         lk_paddr,
    output logic                                lk_ref,
    output logic                                lk_dirty,
    input  logic                                fill_en,
    input  logic [tlb_pkg::VPN_W-1:0]           fill_vpn,
    input  logic [tlb_pkg::PPN_W-1:0]           fill_ppn
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    vpn_t             lk_vpn;
    fill_req_t        fill;
    logic [IDX_W-1:0] victim;
    logic [ENTRIES-1:0] valid_vec, used_vec, mod_vec, match_vec, fmatch_vec;
    ppn_t             ppn_arr [ENTRIES];
    logic             any_hit;
    ppn_t             hit_ppn;
    logic             hit_used, hit_mod;

    assign lk_vpn = vpn_of(lk_vaddr);
    assign fill   = '{en: fill_en, vpn: fill_vpn, ppn: fill_ppn};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush),
            .ref_clr    (ref_clr),
            .lk_valid   (lk_valid),
            .lk_write   (lk_write),
            .lk_vpn     (lk_vpn),
            .fill_sel   (fill.en && (victim == IDX_W'(g))),
            .fill       (fill),
            .valid_o    (valid_vec[g]),
            .used_o     (used_vec[g]),
            .modified_o (mod_vec[g]),
            .ppn_o      (ppn_arr[g]),
            .lk_match   (match_vec[g]),
            .fill_match (fmatch_vec[g])
        );
    end

    tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .used_vec   (used_vec),
        .fmatch_vec (fmatch_vec),
        .victim     (victim)
    );

    tlb_hit_mux #(.ENTRIES(ENTRIES)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .match_vec (match_vec),
        .used_vec  (used_vec),
        .mod_vec   (mod_vec),
        .ppn_arr   (ppn_arr),
        .any_hit   (any_hit),
        .hit_ppn   (hit_ppn),
        .hit_used  (hit_used),
        .hit_mod   (hit_mod)
    );

    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_paddr = join_paddr(hit_ppn, lk_vaddr[PAGE_OFS_W-1:0]);
    assign lk_ref   = lk_hit && hit_used;
    assign lk_dirty = lk_hit && hit_mod;

    // R3: hit and miss are exclusive
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    // R3: no lookup, no result
    a_r3_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    // R11: right after a flush nothing can hit
    a_r11_flush_miss: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R1: nothing hits in the first cycle after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> !lk_hit);

endmodule

// File: tb/tb_tlb_translator.sv
module tb_tlb_translator;
    import tlb_pkg::*;

    localparam int unsigned N = 8;

    logic clk = 1'b0;
    logic rst, flush, ref_clr, lk_valid, lk_write, fill_en;
    logic [VADDR_W-1:0] lk_vaddr;
    logic [PADDR_W-1:0] lk_paddr;
    logic lk_hit, lk_miss, lk_ref, lk_dirty;
    logic [VPN_W-1:0] fill_vpn;
    logic [PPN_W-1:0] fill_ppn;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tlb_translator #(.ENTRIES(N)) dut (
        .clk(clk), .rst(rst), .flush(flush), .ref_clr(ref_clr),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; ref_clr = 0; lk_valid = 0; lk_write = 0; fill_en = 0;
    endtask

    // One cycle: inputs set at falling edge, results sampled 1 ns later,
    // state update at the following rising edge.
    task automatic look(string req, logic [VPN_W-1:0] vpn, pofs_t ofs, logic wr,
                        logic exp_hit, logic [PPN_W-1:0] exp_ppn,
                        logic exp_ref, logic exp_dirty);
        @(negedge clk);
        lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, ofs};
        #1;
        check(req, {62'd0, lk_hit, lk_miss}, {62'd0, exp_hit, !exp_hit});
        if (exp_hit) begin
            check(req, 64'(lk_paddr), 64'({exp_ppn, ofs}));
            check(req, {62'd0, lk_ref, lk_dirty}, {62'd0, exp_ref, exp_dirty});
        end
        @(negedge clk);
        idle();
    endtask

    task automatic fill(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_ppn = ppn;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        look("R1 reset empty", 20'h00000, 12'h000, 0, 0, '0, 0, 0);
        look("R1 reset empty", 20'h12345, 12'h678, 0, 0, '0, 0, 0);
    endtask

    task automatic t_translate();
        fill(20'hABCDE, 20'h13579);
        look("R2 offset low",  20'hABCDE, 12'h000, 0, 1, 20'h13579, 0, 0);
        look("R2 offset high", 20'hABCDE, 12'hFFF, 0, 1, 20'h13579, 1, 0);
        look("R2 offset mid",  20'hABCDE, 12'h5A3, 0, 1, 20'h13579, 1, 0);
        look("R3 other page misses", 20'hABCDF, 12'h000, 0, 0, '0, 0, 0);
    endtask

    task automatic t_idle_ignored();
        fill(20'h00042, 20'h00777);
        // lookup not valid: no result and no status change
        @(negedge clk);
        lk_valid = 0; lk_write = 1; lk_vaddr = {20'h00042, 12'h010};
        #1;
        check("R3 idle no result", {62'd0, lk_hit, lk_miss}, 64'd0);
        @(negedge clk);
        idle();
        look("R3 idle leaves status", 20'h00042, 12'h010, 0, 1, 20'h00777, 0, 0);
        look("R4 use bit set by hit", 20'h00042, 12'h010, 0, 1, 20'h00777, 1, 0);
    endtask

    task automatic t_dirty();
        look("R5 read keeps clean", 20'h00042, 12'h0, 0, 1, 20'h00777, 1, 0);
        look("R5 write hit",        20'h00042, 12'h0, 1, 1, 20'h00777, 1, 0);
        look("R5 dirty visible",    20'h00042, 12'h0, 0, 1, 20'h00777, 1, 1);
    endtask

    task automatic t_ref_clear();
        @(negedge clk);
        ref_clr = 1;
        @(negedge clk);
        idle();
        look("R6 use cleared, dirty kept", 20'h00042, 12'h0, 0, 1, 20'h00777, 0, 1);
        look("R6 other use cleared", 20'hABCDE, 12'h0, 0, 1, 20'h13579, 0, 0);
        // clear together with a hit on 0x00042
        @(negedge clk);
        ref_clr = 1; lk_valid = 1; lk_vaddr = {20'h00042, 12'h0};
        @(negedge clk);
        idle();
        look("R6 hit wins over clear", 20'h00042, 12'h0, 0, 1, 20'h00777, 1, 1);
        look("R6 non-hit cleared", 20'hABCDE, 12'h0, 0, 1, 20'h13579, 0, 0);
    endtask

    task automatic t_replace();
        pulse_flush();
        for (int i = 0; i < N; i++) fill(20'h00100 + i, 20'h00200 + i);
        for (int i = 0; i < N; i++)
            look("R8 free slots filled in order", 20'h00100 + i, 12'h0, 0, 1,
                 20'h00200 + i, 0, 0);
        @(negedge clk); ref_clr = 1; @(negedge clk); idle();
        for (int i = 0; i < N; i++)
            if (i != 3 && i != 5)
                look("R9 touch", 20'h00100 + i, 12'h0, 0, 1, 20'h00200 + i, 0, 0);
        fill(20'h001AA, 20'h00AAA);
        look("R9 lowest cold evicted", 20'h00103, 12'h0, 0, 0, '0, 0, 0);
        look("R9 higher cold kept", 20'h00105, 12'h0, 0, 1, 20'h00205, 0, 0);
        look("R10 new slot fresh", 20'h001AA, 12'h0, 0, 1, 20'h00AAA, 0, 0);
        fill(20'h001BB, 20'h00BBB);
        look("R9 all warm evicts slot 0", 20'h00100, 12'h0, 0, 0, '0, 0, 0);
        look("R9 slot 1 kept", 20'h00101, 12'h0, 0, 1, 20'h00201, 1, 0);
        look("R9 new page present", 20'h001BB, 12'h0, 0, 1, 20'h00BBB, 0, 0);
    endtask

    task automatic t_refill_same();
        look("R7 prepare dirty", 20'h00102, 12'h0, 1, 1, 20'h00202, 1, 0);
        fill(20'h00102, 20'h003CC);
        look("R7 same page overwritten", 20'h00102, 12'h0, 0, 1, 20'h003CC, 0, 0);
        look("R7 slot 1 kept", 20'h00101, 12'h0, 0, 1, 20'h00201, 1, 0);
        for (int i = 4; i < N; i++)
            look("R7 others kept", 20'h00100 + i, 12'h0, 0, 1, 20'h00200 + i, 1, 0);
        look("R7 page AA kept", 20'h001AA, 12'h0, 0, 1, 20'h00AAA, 1, 0);
        look("R7 page BB kept", 20'h001BB, 12'h0, 0, 1, 20'h00BBB, 1, 0);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1; fill_en = 1; fill_vpn = 20'h0CAFE; fill_ppn = 20'h0BEEF;
        @(negedge clk);
        idle();
        look("R11 flush beats fill", 20'h0CAFE, 12'h0, 0, 0, '0, 0, 0);
        look("R11 flush empties", 20'h00101, 12'h0, 0, 0, '0, 0, 0);
        look("R11 flush empties", 20'h001BB, 12'h0, 0, 0, '0, 0, 0);
        fill(20'h0CAFE, 20'h0BEEF);
        look("R8 refill after flush", 20'h0CAFE, 12'h321, 0, 1, 20'h0BEEF, 0, 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        lk_vaddr = '0; fill_vpn = '0; fill_ppn = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_translate();
        t_idle_ignored();
        t_dirty();
        t_ref_clear();
        t_replace();
        t_refill_same();
        t_flush();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule